// File: doc/BRIEF.md
# Serial Signed/Unsigned Integer Divider

This block divides a 32-bit or 16-bit integer dividend by a 16-bit divisor. It returns a 16-bit quotient and a 16-bit remainder. It resolves one quotient bit per clock, and every division takes the same number of cycles whatever its mode. Two mode inputs pick one of four operations: signed or unsigned arithmetic, and a dividend that is either a full high:low word pair or the low word alone.

A request is a one-cycle `start_i` while the block is idle. The operands and mode bits are captured on that edge. `busy_o` stays high while the iterations run. A one-cycle `done_o` then presents the results and an overflow flag, and these outputs hold until the next division completes.

Internally the operands are first turned into magnitudes. An unsigned restoring recurrence then runs for sixteen steps, and signs are applied to the results in a final cycle. An overflow that can be known in advance (a zero divisor, or a high magnitude word not below the divisor) is found when the operands are captured. The signed range check is made once the quotient magnitude is known.

Top module: `intdiv_serial`

## Requirements
- R1: The mode bits select four operations: `sgn_i`=1 is two's-complement signed, 0 is unsigned; `wide_i`=1 takes the dividend as {`dvd_hi_i`,`dvd_lo_i`}, 0 takes `dvd_lo_i` alone.
- R2: In unsigned mode, when no overflow occurs, `quot_o` is the floor of dividend/divisor and `rem_o` is dividend − quotient×divisor.
- R3: In signed mode the quotient is truncated toward zero, and the remainder is zero or carries the sign of the dividend.
- R4: With `wide_i`=0, `dvd_hi_i` has no effect on the result. The low word is sign-extended in signed mode and zero-extended in unsigned mode.
- R5: `done_o` is high for exactly one cycle, 17 rising edges after the edge that accepted `start_i`. This holds identically in all four modes.
- R6: `busy_o` is high in every cycle from the one after acceptance up to the `done_o` cycle, and is low in the `done_o` cycle.
- R7: A `start_i` that arrives while `busy_o` is high is ignored. The running division's results and timing are unchanged.
- R8: A divisor of zero sets `ovf_o` in the `done_o` cycle.
- R9: `ovf_o` is set when the true quotient lies outside 0..65535 (unsigned) or −32768..32767 (signed). Otherwise it is clear, and the quotient and remainder are valid.
- R10: `quot_o`, `rem_o` and `ovf_o` change only in a `done_o` cycle and hold their values between completions.
- R11: During reset and after it, `busy_o`, `done_o`, `ovf_o`, `quot_o` and `rem_o` are all zero until the first division completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request pulse, accepted only when idle |
| sgn_i | input | 1 | 1 = signed, 0 = unsigned |
| wide_i | input | 1 | 1 = 32-bit dividend, 0 = 16-bit dividend |
| dvd_hi_i | input | 16 | Dividend upper word (used when wide) |
| dvd_lo_i | input | 16 | Dividend lower word |
| dvs_i | input | 16 | Divisor |
| busy_o | output | 1 | Division in progress |
| done_o | output | 1 | One-cycle completion pulse |
| quot_o | output | 16 | Quotient |
| rem_o | output | 16 | Remainder |
| ovf_o | output | 1 | Divide-by-zero or quotient out of range |

## Verification
Directed operands cover every sign combination of a small signed division. This separates truncation toward zero from flooring, and shows which operand gives the remainder its sign. Boundary operands are placed just inside and just outside each quotient range, so an off-by-one in the signed limits shows up as a wrong overflow flag. A zero divisor is tried in each mode, and a junk high word is tried in narrow mode, which exposes a missing extension or a leak of the upper word. Random operands in all four modes, with high words both below and above the divisor, are checked against a behavioural integer model. A second start injected mid-run shows whether a busy request is ignored.

// File: rtl/divs_pkg.sv
package divs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } divs_state_e;

  // Per-operation control captured at acceptance
  typedef struct packed {
    logic sgn;      // signed operation
    logic q_neg;    // quotient must be negated
    logic r_neg;    // remainder must be negated
    logic pre_ovf;  // overflow known before iterating
  } divs_ctl_t;

endpackage

// File: rtl/divs_prep.sv
module divs_prep
  import divs_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0]   hi_i,
  input  logic [W-1:0]   lo_i,
  input  logic [W-1:0]   dvs_i,
  input  logic           sgn_i,
  input  logic           wide_i,
  output logic [2*W-1:0] num_mag_o,
  output logic [W-1:0]   dvs_mag_o,
  output divs_ctl_t      ctl_o
);

  localparam int DW = 2 * W;

  logic [DW-1:0] num_raw;
  logic          num_sgn;
  logic          dvs_sgn;
  logic          dvs_zero;

  // Narrow dividends are extended according to the arithmetic mode
  always_comb begin
    if (wide_i) begin
      num_raw = {hi_i, lo_i};
    end else if (sgn_i) begin
      num_raw = {{W{lo_i[W-1]}}, lo_i};
    end else begin
      num_raw = {{W{1'b0}}, lo_i};
    end
  end

  assign num_sgn   = sgn_i & num_raw[DW-1];
  assign dvs_sgn   = sgn_i & dvs_i[W-1];
  assign dvs_zero  = (dvs_i == '0);

  assign num_mag_o = num_sgn ? (~num_raw + 1'b1) : num_raw;
  assign dvs_mag_o = dvs_sgn ? (~dvs_i + 1'b1) : dvs_i;

  always_comb begin
    ctl_o.sgn     = sgn_i;
    ctl_o.q_neg   = num_sgn ^ dvs_sgn;
    ctl_o.r_neg   = num_sgn;
    ctl_o.pre_ovf = dvs_zero | (num_mag_o[DW-1:W] >= dvs_mag_o);
  end

endmodule

// File: rtl/divs_step.sv
module divs_step #(
  parameter int W = 16
) (
  input  logic [W-1:0] rem_i,
  input  logic [W-1:0] shq_i,
  input  logic [W-1:0] dvs_i,
  output logic [W-1:0] rem_o,
  output logic [W-1:0] shq_o
);

  logic [W:0]   trial;
  logic [W+1:0] diff;
  logic         take;

  // One restoring step: shift in the next dividend bit, try to subtract
  assign trial = {rem_i, shq_i[W-1]};
  assign diff  = {1'b0, trial} - {2'b00, dvs_i};
  assign take  = ~diff[W+1];

  assign rem_o = take ? diff[W-1:0] : trial[W-1:0];
  assign shq_o = {shq_i[W-2:0], take};

endmodule

// File: rtl/divs_fix.sv
module divs_fix
  import divs_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] qmag_i,
  input  logic [W-1:0] rmag_i,
  input  divs_ctl_t    ctl_i,
  output logic [W-1:0] quot_o,
  output logic [W-1:0] rem_o,
  output logic         ovf_o
);

  localparam logic [W-1:0] NEG_LIM = {1'b1, {(W-1){1'b0}}};

  logic range_bad;

  // Signed quotients must fit the two's-complement range of W bits
  always_comb begin
    if (!ctl_i.sgn) begin
      range_bad = 1'b0;
    end else if (ctl_i.q_neg) begin
      range_bad = (qmag_i > NEG_LIM);
    end else begin
      range_bad = qmag_i[W-1];
    end
  end

  assign ovf_o  = ctl_i.pre_ovf | range_bad;
  assign quot_o = ctl_i.q_neg ? (~qmag_i + 1'b1) : qmag_i;
  assign rem_o  = ctl_i.r_neg ? (~rmag_i + 1'b1) : rmag_i;

endmodule

// File: rtl/intdiv_serial.sv
module intdiv_serial
  import divs_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         sgn_i,
  input  logic         wide_i,
  input  logic [W-1:0] dvd_hi_i,
  input  logic [W-1:0] dvd_lo_i,
  input  logic [W-1:0] dvs_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] quot_o,
  output logic [W-1:0] rem_o,
  output logic         ovf_o
);

  localparam int            CW   = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);
  localparam int            LW   = $clog2(W + 2) + 1;
  localparam logic [LW-1:0] LAT  = LW'(W + 1);

  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  // Operand conditioning
  logic [2*W-1:0] num_mag;
  logic [W-1:0]   dvs_mag;
  divs_ctl_t      ctl_in;

  divs_prep #(.W(W)) u_prep (
    .hi_i      (dvd_hi_i),
    .lo_i      (dvd_lo_i),
    .dvs_i     (dvs_i),
    .sgn_i     (sgn_i),
    .wide_i    (wide_i),
    .num_mag_o (num_mag),
    .dvs_mag_o (dvs_mag),
    .ctl_o     (ctl_in)
  );

  // State and datapath registers
  divs_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [W-1:0]  rem_q, rem_d;
  logic [W-1:0]  shq_q, shq_d;
  logic [W-1:0]  dvs_q, dvs_d;
  divs_ctl_t     ctl_q, ctl_d;
  logic          done_q, done_d;
  logic [W-1:0]  quot_q, remo_q;
  logic          ovf_q;
  logic          accept;
  logic          dp_en;
  logic          out_en;

  logic [W-1:0]  step_rem, step_shq;
  logic [W-1:0]  fix_q, fix_r;
  logic          fix_ovf;

  divs_step #(.W(W)) u_step (
    .rem_i (rem_q),
    .shq_i (shq_q),
    .dvs_i (dvs_q),
    .rem_o (step_rem),
    .shq_o (step_shq)
  );

  divs_fix #(.W(W)) u_fix (
    .qmag_i (shq_q),
    .rmag_i (rem_q),
    .ctl_i  (ctl_q),
    .quot_o (fix_q),
    .rem_o  (fix_r),
    .ovf_o  (fix_ovf)
  );

  assign accept = (state_q == ST_IDLE) && start_i;
  assign dp_en  = accept || (state_q == ST_RUN);
  assign out_en = (state_q == ST_FIX);

  // Next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    rem_d   = rem_q;
    shq_d   = shq_q;
    dvs_d   = dvs_q;
    ctl_d   = ctl_q;
    done_d  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_RUN;
          cnt_d   = '0;
          rem_d   = num_mag[2*W-1:W];
          shq_d   = num_mag[W-1:0];
          dvs_d   = dvs_mag;
          ctl_d   = ctl_in;
        end
      end
      ST_RUN: begin
        rem_d = step_rem;
        shq_d = step_shq;
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == LAST) state_d = ST_FIX;
      end
      ST_FIX: begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Control registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
    end
  end

  // Datapath registers, enabled on acceptance and iteration
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rem_q <= '0;
      shq_q <= '0;
      dvs_q <= '0;
      ctl_q <= '0;
    end else if (dp_en) begin
      rem_q <= rem_d;
      shq_q <= shq_d;
      dvs_q <= dvs_d;
      ctl_q <= ctl_d;
    end
  end

  // Result registers, enabled in the sign-fix cycle
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      quot_q <= '0;
      remo_q <= '0;
      ovf_q  <= 1'b0;
    end else if (out_en) begin
      quot_q <= fix_q;
      remo_q <= fix_r;
      ovf_q  <= fix_ovf;
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;
  assign quot_o = quot_q;
  assign rem_o  = remo_q;
  assign ovf_o  = ovf_q;

  // Latency observer for the timing property
  logic [LW-1:0] lat_q;
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  lat_q <= '0;
    else if (accept)  lat_q <= '0;
    else if (busy_o)  lat_q <= lat_q + 1'b1;
  end

  p_start_busy_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (start_i && !busy_o) |=> busy_o);

  p_ignore_start_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    busy_o |=> ($stable(dvs_q) && $stable(ctl_q)));

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done_o |=> !done_o);

  p_latency_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done_o |-> (lat_q == LAT));

  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done_o |-> !busy_o);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!$stable(quot_o) || !$stable(rem_o) || !$stable(ovf_o)) |-> done_o);

  p_divzero_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (done_o && (dvs_q == '0)) |-> ovf_o);

  p_rem_bound_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((state_q == ST_RUN) && !ctl_q.pre_ovf) |-> (rem_q < dvs_q));

endmodule

// File: tb/sim_intdiv_serial.sv
module sim_intdiv_serial;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        sgn = 1'b0;
  logic        wide = 1'b0;
  logic [15:0] hi = '0, lo = '0, dv = '0;
  logic        busy, done, ovf;
  logic [15:0] quot, rem;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  intdiv_serial #(.W(16)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .sgn_i(sgn), .wide_i(wide),
    .dvd_hi_i(hi), .dvd_lo_i(lo), .dvs_i(dv),
    .busy_o(busy), .done_o(done), .quot_o(quot), .rem_o(rem), .ovf_o(ovf)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Behavioural integer model
  task automatic model(input bit s, input bit w, input logic [15:0] h,
                       input logic [15:0] l, input logic [15:0] d,
                       output bit eo, output logic [15:0] eq, output logic [15:0] er);
    longint a, b, qq, rr;
    if (!s) begin
      a = w ? longint'({h, l}) : longint'(l);
      b = longint'(d);
    end else begin
      a = w ? longint'($signed({h, l})) : longint'($signed(l));
      b = longint'($signed(d));
    end
    if (b == 0) begin
      eo = 1'b1; eq = '0; er = '0;
    end else begin
      qq = a / b;
      rr = a % b;
      eo = s ? (qq > 32767 || qq < -32768) : (qq > 65535);
      eq = qq[15:0];
      er = rr[15:0];
    end
  endtask

  task automatic run(input bit s, input bit w, input logic [15:0] h,
                     input logic [15:0] l, input logic [15:0] d,
                     input string req, input bit poke);
    bit eo;
    logic [15:0] eq, er;
    model(s, w, h, l, d, eo, eq, er);
    @(negedge clk);
    sgn = s; wide = w; hi = h; lo = l; dv = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy && !done, "R6", "busy after accept", busy, 1);
    for (int i = 2; i <= 17; i++) begin
      @(negedge clk);
      chk(busy, "R6", "busy during run", busy, 1);
      chk(!done, "R5", "early done", done, 0);
      if (poke && i == 5) begin
        start = 1'b1; hi = ~h; lo = ~l; dv = d + 16'd1; sgn = ~s;
      end else begin
        start = 1'b0;
      end
    end
    start = 1'b0;
    @(negedge clk);
    chk(done, "R5", "done at edge 17", done, 1);
    chk(!busy, "R6", "busy low at done", busy, 0);
    chk(ovf == eo, eo ? req : "R9", "ovf", ovf, eo);
    if (!eo) begin
      chk(quot == eq, req, "quotient", quot, eq);
      chk(rem == er, req, "remainder", rem, er);
    end
    @(negedge clk);
    chk(!done, "R5", "done one cycle", done, 0);
    chk(ovf == eo, "R10", "ovf held", ovf, eo);
    if (!eo) begin
      chk(quot == eq, "R10", "quotient held", quot, eq);
      chk(rem == er, "R10", "remainder held", rem, er);
    end
  endtask

  initial begin
    #(20 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] d, h;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(!busy && !done && !ovf, "R11", "flags in reset", {busy, done, ovf}, 0);
    chk(quot == 0 && rem == 0, "R11", "results in reset", quot, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(!busy && !done && !ovf && quot == 0, "R11", "idle after reset", {busy, done, ovf}, 0);

    // R2: unsigned
    run(0, 1, 16'h0001, 16'h2345, 16'h0100, "R2", 0);
    run(0, 1, 16'hFFFE, 16'hFFFF, 16'hFFFF, "R2", 0);
    run(0, 0, 16'h0000, 16'd50000, 16'd7, "R2", 0);
    // R3: signed sign combinations
    run(1, 0, 16'h0000, 16'hFFF9, 16'd2, "R3", 0);
    run(1, 0, 16'h0000, 16'd7, 16'hFFFE, "R3", 0);
    run(1, 0, 16'h0000, 16'hFFF9, 16'hFFFE, "R3", 0);
    run(1, 1, 16'hFFFF, 16'h0000, 16'd2, "R3", 0);
    // R4: high word ignored in narrow mode
    run(0, 0, 16'hABCD, 16'd1000, 16'd7, "R4", 0);
    run(1, 0, 16'h1234, 16'hFF00, 16'd16, "R4", 0);
    // R8: zero divisor in all modes
    run(0, 0, 16'h0000, 16'd5, 16'd0, "R8", 0);
    run(0, 1, 16'h0000, 16'd5, 16'd0, "R8", 0);
    run(1, 0, 16'h0000, 16'd5, 16'd0, "R8", 0);
    run(1, 1, 16'hFFFF, 16'hFFFB, 16'd0, "R8", 0);
    // R9: range limits
    run(1, 1, 16'h0001, 16'h0000, 16'd2, "R9", 0);
    run(0, 1, 16'h0001, 16'h0000, 16'd1, "R9", 0);
    run(1, 0, 16'h0000, 16'h8000, 16'hFFFF, "R9", 0);
    run(1, 1, 16'h8000, 16'h0000, 16'hFFFF, "R9", 0);
    // R7: start while busy
    run(0, 1, 16'h0012, 16'h3456, 16'h0789, "R7", 1);
    run(1, 0, 16'h0000, 16'hF000, 16'd3, "R7", 1);
    // R1: random operands in all four modes
    for (int m = 0; m < 4; m++) begin
      for (int k = 0; k < 30; k++) begin
        d = 16'($urandom);
        if (k % 7 == 0) d = 16'($urandom % 9);
        if (m[1] == 1'b0) h = (d != 0 && k % 2 == 0) ? 16'($urandom % d) : 16'($urandom);
        else              h = (k % 2 == 0) ? 16'h0000 : 16'hFFFF;
        run(m[1], m[0], h, 16'($urandom), d, "R1", 0);
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule